// File: doc/BRIEF.md
# SMBus Master Byte Transaction Sequencer

This block is the master-side control engine of a byte-oriented SMBus/I2C host controller. Software programs it through a small bank of 8-bit registers: it asks for START and STOP conditions through a control register and moves address and data bytes through a data register. The sequencer turns those accesses into operations on an abstract byte-level bus port. The port has four operations: begin a transfer (7-bit target address plus direction, answered by ack or nack), send a byte (answered by ack or nack), receive a byte (returns data) and end the transfer. Each operation runs on a request/done handshake and may take any number of cycles.

STOP is deferred in two cases. During a read, a STOP takes effect only after software has read the last byte. After a negative acknowledge, it takes effect only once software clears the nack flag. While the bus is receiving, each read of the data register returns the byte already held and starts the fetch of the next one. While any bus operation is outstanding, every register write and every data-register side effect is ignored. Software can see that an operation is outstanding on the bus request line.

Register map (3-bit index): 0 data, 1 status, 2 control-status, 3 control, 4 enable/config, 5 end-of-busy. Status bits: 0 master, 1 transmit, 2 data-ready, 3 nack, 4 bus-error, 5 stall. Control-status bits: 0 busy, 1 bus-busy. Control bits: 0 START (write-only pulse), 1 STOP (write-only pulse), 2 stall-after-address enable. Enable/config: all 8 bits are stored, and bit 0 is the enable. End-of-busy: bit 0. Bus operation codes: 0 begin, 1 send, 2 receive, 3 end.

Top module: `smb_xact_seq`

## Requirements
- R1: After reset every register reads 0 and no bus operation is requested.
- R2: A START request succeeds when bus_busy_in is low or the sequencer is not in its idle state (repeated start). Success sets status master, transmit and data-ready, and sets control-status busy and bus-busy.
- R3: A START request with bus_busy_in high while idle fails. Failure clears master and busy and sets bus-error. Bus-busy is set either way, and the state returns to idle.
- R4: In master mode and idle, a data write issues a begin operation. The target address is write data bits 7:1 and the direction is bit 0 (1 = read). Writes to status bits 4 and 5 and to end-of-busy bit 0 clear those flags.
- R5: A nacked address sets nack, clears data-ready and sets transmit to the inverse of the direction. Later data writes start no bus operation until a stop completes.
- R6: An acked address clears nack and enters sending or receiving. With stall enabled it sets stall, and for a write it also sets data-ready, with no further bus operation.
- R7: An acked read address with stall disabled fetches a byte at once. The byte lands in the data register and data-ready is set.
- R8: In the sending state a data write issues a send of that byte. An ack sets data-ready. A nack clears data-ready and sets nack.
- R9: In the receiving state a data read returns the held byte and starts the fetch of the next byte.
- R10: A STOP while receiving is deferred. The next data read returns the byte and then ends the transfer. Ending clears status and control-status and sets end-of-busy.
- R11: A STOP after a nack is deferred until 1 is written to status bit 3. An immediate STOP in any other master state ends the transfer at once.
- R12: Writing 1 to status bit 5 while receiving fetches a byte.
- R13: Writing 0 to enable bit 0 clears the control register, status, control-status and end-of-busy.
- R14: While a bus operation is outstanding, the request and its operation fields stay stable, and register writes and data-read side effects are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_busy_in | input | 1 | Another master holds the bus |
| bus_req | output | 1 | Bus operation request, held until done |
| bus_op | output | 2 | Operation code |
| bus_addr | output | 7 | Target address for begin |
| bus_rnw | output | 1 | Direction for begin, 1 = read |
| bus_wdata | output | 8 | Byte for send |
| bus_done | input | 1 | One-cycle completion pulse |
| bus_ack | input | 1 | Ack result of begin or send |
| bus_rdata | input | 8 | Byte returned by receive |

## Verification
The checker watches, on every cycle, that a pending bus request holds its operation fields until done and that a begin is only ever raised by a data write. It also checks that a completed end operation leaves status and control-status cleared with end-of-busy set, that a disable write clears the state it owns, and the flag outcome of every successful or failed START. Only the bench scenarios can show the deferred STOP orderings and the values of the bytes moved. The same holds for the chaining of a receive behind an acked read address and for accesses ignored while the responder withholds completion.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_TX        = 3'd1,
        S_RX        = 3'd2,
        S_NACK      = 3'd3,
        S_STOP_RX   = 3'd4,
        S_STOP_NACK = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_BEGIN = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_END   = 2'd3
    } bus_op_e;

    // register indices
    localparam int RA_DATA = 0;
    localparam int RA_STAT = 1;
    localparam int RA_CST  = 2;
    localparam int RA_CTRL = 3;
    localparam int RA_CFG  = 4;
    localparam int RA_EOB  = 5;
    localparam int NUM_REGS = 6;

    // bit positions
    localparam int CB_START = 0;
    localparam int CB_STOP  = 1;
    localparam int CB_STALL = 2;
    localparam int SB_NACK  = 3;
    localparam int SB_BERR  = 4;
    localparam int SB_STALL = 5;
    localparam int GB_BB    = 1;

    typedef struct packed {
        logic stall;
        logic berr;
        logic nack;
        logic rdy;
        logic xmit;
        logic master;
    } stat_t;

    typedef struct packed {
        logic bb;
        logic busy;
    } cstat_t;

endpackage

// File: rtl/smb_reg_dec.sv
module smb_reg_dec #(
    parameter int AW   = 3,
    parameter int DW   = 8,
    parameter int NREG = 6
) (
    input  logic                     allow,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [AW-1:0]            reg_addr,
    input  logic [NREG-1:0][DW-1:0]  reg_vals,
    output logic [NREG-1:0]          wr_hit,
    output logic                     rd_data,
    output logic [DW-1:0]            rdata
);

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign wr_hit[i] = allow && reg_wr && (reg_addr == AW'(i));
    end

    assign rd_data = allow && reg_rd && (reg_addr == AW'(smb_seq_pkg::RA_DATA));

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (reg_addr == AW'(i)) rdata = reg_vals[i];
        end
    end

endmodule

// File: rtl/smb_seq_core.sv
module smb_seq_core
    import smb_seq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] wr_hit,
    input  logic            rd_data,
    input  logic [DW-1:0]   wdata,
    input  logic            bus_busy_i,
    input  logic            bus_done_i,
    input  logic            bus_ack_i,
    input  logic [DW-1:0]   bus_rdata_i,
    output logic            bus_req_o,
    output bus_op_e         bus_op_o,
    output logic [DW-2:0]   bus_addr_o,
    output logic            bus_rnw_o,
    output logic [DW-1:0]   bus_wdata_o,
    output logic [DW-1:0]   data_o,
    output stat_t           stat_o,
    output cstat_t          cst_o,
    output logic            eob_o,
    output logic            stall_en_o,
    output logic [DW-1:0]   cfg_o,
    output seq_state_e      state_o
);

    localparam int TAW = DW - 1;

    typedef struct packed {
        seq_state_e      state;
        stat_t           stat;
        cstat_t          cst;
        logic            eob;
        logic            stall_en;
        logic [DW-1:0]   cfg;
        logic [DW-1:0]   data;
        logic            req;
        bus_op_e         op;
        logic [TAW-1:0]  addr;
        logic            rnw;
        logic [DW-1:0]   wbyte;
    } core_t;

    core_t q, d;
    logic  avail;

    always_comb begin
        d     = q;
        avail = 1'b0;
        if (q.req) begin
            if (bus_done_i) begin
                d.req = 1'b0;
                unique case (q.op)
                    OP_BEGIN: begin
                        d.stat.xmit = !q.rnw;
                        if (!bus_ack_i) begin
                            d.stat.rdy  = 1'b0;
                            d.stat.nack = 1'b1;
                            d.state     = S_NACK;
                        end else begin
                            d.stat.nack = 1'b0;
                            d.state     = q.rnw ? S_RX : S_TX;
                            if (q.stall_en) begin
                                d.stat.stall = 1'b1;
                                if (!q.rnw) d.stat.rdy = 1'b1;
                            end else if (q.rnw) begin
                                d.req = 1'b1;
                                d.op  = OP_RECV;
                            end
                        end
                    end
                    OP_SEND: begin
                        if (bus_ack_i) begin
                            d.stat.rdy = 1'b1;
                        end else begin
                            d.stat.rdy  = 1'b0;
                            d.stat.nack = 1'b1;
                            d.state     = S_NACK;
                        end
                    end
                    OP_RECV: begin
                        d.data     = bus_rdata_i;
                        d.stat.rdy = 1'b1;
                    end
                    default: begin
                        d.stat  = '0;
                        d.cst   = '0;
                        d.state = S_IDLE;
                        d.eob   = 1'b1;
                    end
                endcase
            end
        end else begin
            if (wr_hit[RA_DATA]) begin
                d.data = wdata;
                if (q.stat.master) begin
                    if (q.state == S_IDLE) begin
                        d.req  = 1'b1;
                        d.op   = OP_BEGIN;
                        d.addr = wdata[DW-1:1];
                        d.rnw  = wdata[0];
                    end else if (q.state == S_TX) begin
                        d.req   = 1'b1;
                        d.op    = OP_SEND;
                        d.wbyte = wdata;
                    end
                end
            end
            if (wr_hit[RA_STAT]) begin
                if (wdata[SB_BERR])  d.stat.berr  = 1'b0;
                if (wdata[SB_STALL]) d.stat.stall = 1'b0;
                if (wdata[SB_NACK]) begin
                    d.stat.nack = 1'b0;
                    if (q.state == S_STOP_NACK) begin
                        d.req = 1'b1;
                        d.op  = OP_END;
                    end
                end
                if (wdata[SB_STALL] && q.state == S_RX) begin
                    d.req = 1'b1;
                    d.op  = OP_RECV;
                end
            end
            if (wr_hit[RA_CST] && wdata[GB_BB]) d.cst.bb = 1'b0;
            if (wr_hit[RA_CTRL]) begin
                d.stall_en = wdata[CB_STALL];
                if (wdata[CB_START]) begin
                    avail = !bus_busy_i || (q.state != S_IDLE);
                    if (avail) begin
                        d.stat.master = 1'b1;
                        d.stat.xmit   = 1'b1;
                        d.stat.rdy    = 1'b1;
                        d.cst.busy    = 1'b1;
                    end else begin
                        d.stat.master = 1'b0;
                        d.cst.busy    = 1'b0;
                        d.stat.berr   = 1'b1;
                    end
                    d.cst.bb = 1'b1;
                    d.state  = S_IDLE;
                end
                if (wdata[CB_STOP] && d.stat.master) begin
                    unique case (d.state)
                        S_RX, S_STOP_RX: d.state = S_STOP_RX;
                        S_NACK:          d.state = S_STOP_NACK;
                        default: begin
                            d.req = 1'b1;
                            d.op  = OP_END;
                        end
                    endcase
                end
            end
            if (wr_hit[RA_CFG]) begin
                d.cfg = wdata;
                if (!wdata[0]) begin
                    d.stall_en = 1'b0;
                    d.stat     = '0;
                    d.cst      = '0;
                    d.eob      = 1'b0;
                end
            end
            if (wr_hit[RA_EOB] && wdata[0]) d.eob = 1'b0;
            if (rd_data) begin
                if (q.state == S_STOP_RX) begin
                    d.req = 1'b1;
                    d.op  = OP_END;
                end else if (q.state == S_RX) begin
                    d.req = 1'b1;
                    d.op  = OP_RECV;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.op    <= OP_BEGIN;
        end else begin
            q <= d;
        end
    end

    assign bus_req_o   = q.req;
    assign bus_op_o    = q.op;
    assign bus_addr_o  = q.addr;
    assign bus_rnw_o   = q.rnw;
    assign bus_wdata_o = q.wbyte;
    assign data_o      = q.data;
    assign stat_o      = q.stat;
    assign cst_o       = q.cst;
    assign eob_o       = q.eob;
    assign stall_en_o  = q.stall_en;
    assign cfg_o       = q.cfg;
    assign state_o     = q.state;

endmodule

// File: rtl/smb_xact_seq.sv
module smb_xact_seq
    import smb_seq_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          bus_busy_in,
    output logic          bus_req,
    output logic [1:0]    bus_op,
    output logic [DW-2:0] bus_addr,
    output logic          bus_rnw,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_done,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);

    localparam int NREG = NUM_REGS;

    logic [NREG-1:0]         wr_hit;
    logic                    rd_data;
    logic [NREG-1:0][DW-1:0] reg_vals;
    logic [DW-1:0]           data_w, cfg_w;
    stat_t                   stat_s;
    cstat_t                  cst_s;
    logic                    eob_w, stall_en_w;
    seq_state_e              state_s;
    bus_op_e                 op_s;
    logic [DW-1:0]           stat_w, cst_w;
    logic [2:0]              state_w;

    assign stat_w  = DW'(stat_s);
    assign cst_w   = DW'(cst_s);
    assign state_w = state_s;
    assign bus_op  = op_s;

    always_comb begin
        reg_vals          = '0;
        reg_vals[RA_DATA] = data_w;
        reg_vals[RA_STAT] = stat_w;
        reg_vals[RA_CST]  = cst_w;
        reg_vals[RA_CTRL] = DW'({stall_en_w, 2'b00});
        reg_vals[RA_CFG]  = cfg_w;
        reg_vals[RA_EOB]  = DW'(eob_w);
    end

    smb_reg_dec #(.AW(AW), .DW(DW), .NREG(NREG)) u_dec (
        .allow    (!bus_req),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_vals (reg_vals),
        .wr_hit   (wr_hit),
        .rd_data  (rd_data),
        .rdata    (reg_rdata)
    );

    smb_seq_core #(.DW(DW), .NREG(NREG)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (wr_hit),
        .rd_data     (rd_data),
        .wdata       (reg_wdata),
        .bus_busy_i  (bus_busy_in),
        .bus_done_i  (bus_done),
        .bus_ack_i   (bus_ack),
        .bus_rdata_i (bus_rdata),
        .bus_req_o   (bus_req),
        .bus_op_o    (op_s),
        .bus_addr_o  (bus_addr),
        .bus_rnw_o   (bus_rnw),
        .bus_wdata_o (bus_wdata),
        .data_o      (data_w),
        .stat_o      (stat_s),
        .cst_o       (cst_s),
        .eob_o       (eob_w),
        .stall_en_o  (stall_en_w),
        .cfg_o       (cfg_w),
        .state_o     (state_s)
    );

endmodule

// File: rtl/smb_xact_seq_chk.sv
module smb_xact_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       bus_busy_in,
    input logic       bus_req,
    input logic       bus_done,
    input logic [1:0] bus_op,
    input logic [6:0] bus_addr,
    input logic       bus_rnw,
    input logic [7:0] bus_wdata,
    input logic [7:0] stat_w,
    input logic [7:0] cst_w,
    input logic       eob_w,
    input logic [2:0] state_w
);

    logic start_wr;
    assign start_wr = !bus_req && reg_wr && reg_addr == 3'd3 && reg_wdata[0] && !reg_wdata[1];

    // R14: pending request holds its fields
    a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_op) && $stable(bus_addr)
                                    && $stable(bus_rnw) && $stable(bus_wdata)));

    // R10: finished end operation clears status
    a_r10_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_done && bus_op == 2'd3) |=> (stat_w == 8'h00 && cst_w == 8'h00 && eob_w));

    // R13: disable write
    a_r13_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && reg_wr && reg_addr == 3'd4 && !reg_wdata[0])
        |=> (stat_w == 8'h00 && cst_w == 8'h00 && !eob_w));

    // R3: failed start
    a_r3_start_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && bus_busy_in && state_w == 3'd0)
        |=> (stat_w[4] && !stat_w[0] && cst_w == 8'h02));

    // R2: successful start
    a_r2_start_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && (!bus_busy_in || state_w != 3'd0))
        |=> (stat_w[2:0] == 3'b111 && cst_w == 8'h03));

    // R4: begin raised only by a data write
    a_r4_begin_src: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_req) && bus_op == 2'd0) |-> $past(reg_wr && reg_addr == 3'd0));

endmodule

bind smb_xact_seq smb_xact_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .bus_busy_in (bus_busy_in),
    .bus_req     (bus_req),
    .bus_done    (bus_done),
    .bus_op      (bus_op),
    .bus_addr    (bus_addr),
    .bus_rnw     (bus_rnw),
    .bus_wdata   (bus_wdata),
    .stat_w      (stat_w),
    .cst_w       (cst_w),
    .eob_w       (eob_w),
    .state_w     (state_w)
);

// File: tb/smb_xact_seq_bench.sv
module smb_xact_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       bus_busy_in = 1'b0;
    logic       bus_req;
    logic [1:0] bus_op;
    logic [6:0] bus_addr;
    logic       bus_rnw;
    logic [7:0] bus_wdata;
    logic       bus_done = 1'b0, bus_ack = 1'b0;
    logic [7:0] bus_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int n_ops = 0, n_end = 0, rx_cnt = 0, rx_exp = 0;
    logic       ack_cfg = 1'b1, resp_hold = 1'b0;
    logic [1:0] last_op;
    logic [6:0] last_addr;
    logic       last_rnw;
    logic [7:0] last_wdata;

    localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_CST = 3'd2,
                           A_CTRL = 3'd3, A_CFG = 3'd4, A_EOB = 3'd5;

    always #2.5 clk = ~clk;

    smb_xact_seq u_smb_xact_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_busy_in(bus_busy_in), .bus_req(bus_req), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] rx_val(int k);
        return 8'hA5 ^ 8'(k * 29);
    endfunction

    function automatic logic [7:0] f_stat(logic m, logic x, logic r, logic n, logic b, logic s);
        return {2'b00, s, b, n, r, x, m};
    endfunction

    // bus responder
    initial begin
        int lat;
        logic pulse;
        lat = 0;
        pulse = 1'b0;
        forever begin
            @(negedge clk);
            if (pulse) begin
                bus_done = 1'b0;
                pulse = 1'b0;
            end else if (bus_req && !resp_hold) begin
                if (lat == 0) begin
                    last_op = bus_op; last_addr = bus_addr;
                    last_rnw = bus_rnw; last_wdata = bus_wdata;
                    n_ops++;
                    if (bus_op == 2'd3) n_end++;
                    bus_ack = ack_cfg;
                    if (bus_op == 2'd2) begin
                        bus_rdata = rx_val(rx_cnt);
                        rx_cnt++;
                    end
                    bus_done = 1'b1;
                    pulse = 1'b1;
                    lat = $urandom % 3;
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        while (bus_req) @(negedge clk);
    endtask

    task automatic chk_reg(string tag, logic [2:0] a, logic [7:0] exp);
        logic [7:0] v;
        peek(a, v);
        chk(tag, v, exp);
    endtask

    task automatic write_txn(logic [6:0] ta, int nb, logic stall);
        int  e0;
        logic nacked;
        logic [7:0] b;
        nacked = 1'b0;
        wr(A_CTRL, stall ? 8'h05 : 8'h01);
        chk_reg("R2 start stat", A_STAT, f_stat(1,1,1,0,0,0));
        ack_cfg = 1'b1;
        wr(A_DATA, {ta, 1'b0});
        wait_idle();
        chk("R4 begin addr", {last_op, last_rnw, 5'd0}, {2'd0, 1'b0, 5'd0});
        chk("R4 begin target", {1'b0, last_addr}, {1'b0, ta});
        chk_reg("R6 write ack stat", A_STAT, f_stat(1,1,1,0,0,stall));
        if (stall) begin
            wr(A_STAT, 8'h20);
            chk_reg("R6 stall cleared", A_STAT, f_stat(1,1,1,0,0,0));
        end
        for (int i = 0; i < nb; i++) begin
            b = 8'($urandom);
            ack_cfg = ($urandom % 4) != 0;
            wr(A_DATA, b);
            wait_idle();
            chk("R8 send byte", last_wdata, b);
            if (ack_cfg) chk_reg("R8 ack stat", A_STAT, f_stat(1,1,1,0,0,0));
            else begin
                chk_reg("R8 nack stat", A_STAT, f_stat(1,1,0,1,0,0));
                nacked = 1'b1;
                break;
            end
        end
        e0 = n_end;
        wr(A_CTRL, 8'h02);
        if (nacked) begin
            wait_idle();
            chk("R11 stop deferred", 8'(n_end), 8'(e0));
            wr(A_STAT, 8'h08);
        end
        wait_idle();
        chk("R11 end issued", 8'(n_end), 8'(e0 + 1));
        chk_reg("R10 stat cleared", A_STAT, 8'h00);
        chk_reg("R10 eob set", A_EOB, 8'h01);
        wr(A_EOB, 8'h01);
        chk_reg("R4 eob w1c", A_EOB, 8'h00);
    endtask

    task automatic read_txn(logic [6:0] ta, int nb);
        int e0;
        logic [7:0] v;
        wr(A_CTRL, 8'h01);
        ack_cfg = 1'b1;
        wr(A_DATA, {ta, 1'b1});
        wait_idle();
        chk("R7 first fetch", last_op, 8'd2);
        chk_reg("R7 rx stat", A_STAT, f_stat(1,0,1,0,0,0));
        for (int i = 0; i < nb - 1; i++) begin
            rd(A_DATA, v);
            chk("R9 read byte", v, rx_val(rx_exp));
            rx_exp++;
            wait_idle();
        end
        e0 = n_end;
        wr(A_CTRL, 8'h02);
        wait_idle();
        chk("R10 stop deferred", 8'(n_end), 8'(e0));
        rd(A_DATA, v);
        chk("R10 last byte", v, rx_val(rx_exp));
        rx_exp++;
        wait_idle();
        chk("R10 end after read", 8'(n_end), 8'(e0 + 1));
        chk_reg("R10 stat cleared", A_STAT, 8'h00);
        chk_reg("R10 cst cleared", A_CST, 8'h00);
        wr(A_EOB, 8'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int e0, o0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 6; a++) chk_reg("R1 reset reg", 3'(a), 8'h00);
        chk("R1 no request", 8'(bus_req), 8'h00);

        wr(A_CFG, 8'h01);
        chk_reg("R13 cfg stored", A_CFG, 8'h01);

        // R3 start failure
        bus_busy_in = 1'b1;
        wr(A_CTRL, 8'h01);
        chk_reg("R3 fail stat", A_STAT, f_stat(0,0,0,0,1,0));
        chk_reg("R3 fail cst", A_CST, 8'h02);
        wr(A_STAT, 8'h10);
        chk_reg("R4 berr w1c", A_STAT, 8'h00);
        wr(A_CST, 8'h02);
        chk_reg("R4 bb w1c", A_CST, 8'h00);
        bus_busy_in = 1'b0;

        // R2 repeated start while owner
        wr(A_CTRL, 8'h01);
        wr(A_DATA, 8'h42);
        wait_idle();
        bus_busy_in = 1'b1;
        wr(A_CTRL, 8'h01);
        chk_reg("R2 repeated start stat", A_STAT, f_stat(1,1,1,0,0,0));
        chk_reg("R2 repeated start cst", A_CST, 8'h03);
        bus_busy_in = 1'b0;
        e0 = n_end;
        wr(A_CTRL, 8'h02);
        wait_idle();
        chk("R11 immediate stop", 8'(n_end), 8'(e0 + 1));
        wr(A_EOB, 8'h01);

        // R5 address nack on read
        wr(A_CTRL, 8'h01);
        ack_cfg = 1'b0;
        wr(A_DATA, 8'h31);
        wait_idle();
        chk_reg("R5 nack stat", A_STAT, f_stat(1,0,0,1,0,0));
        o0 = n_ops;
        wr(A_DATA, 8'h55);
        repeat (4) @(negedge clk);
        chk("R5 data write ignored", 8'(n_ops), 8'(o0));
        e0 = n_end;
        wr(A_CTRL, 8'h02);
        repeat (4) @(negedge clk);
        chk("R11 nack stop deferred", 8'(n_end), 8'(e0));
        wr(A_STAT, 8'h08);
        wait_idle();
        chk("R11 stop after nack clear", 8'(n_end), 8'(e0 + 1));
        wr(A_EOB, 8'h01);
        ack_cfg = 1'b1;

        // R6/R12 stalled read
        wr(A_CTRL, 8'h05);
        o0 = n_ops;
        wr(A_DATA, 8'h67);
        wait_idle();
        chk("R6 no fetch while stalled", 8'(n_ops), 8'(o0 + 1));
        chk_reg("R6 stall read stat", A_STAT, f_stat(1,0,1,0,0,1));
        wr(A_STAT, 8'h20);
        wait_idle();
        chk("R12 stall clear fetches", last_op, 8'd2);
        chk_reg("R12 stat", A_STAT, f_stat(1,0,1,0,0,0));
        chk_reg("R12 byte", A_DATA, rx_val(rx_exp));
        rd(A_DATA, v);
        rx_exp++;
        wait_idle();
        wr(A_CTRL, 8'h02);
        rd(A_DATA, v);
        chk("R9 second byte", v, rx_val(rx_exp));
        rx_exp++;
        wait_idle();
        chk_reg("R10 eob", A_EOB, 8'h01);

        // R14 ignored while pending, then R13 disable
        wr(A_CTRL, 8'h01);
        resp_hold = 1'b1;
        wr(A_DATA, 8'h22);
        wr(A_CFG, 8'h00);
        repeat (3) @(negedge clk);
        chk("R14 request held", {bus_req, bus_addr}, {1'b1, 7'h11});
        resp_hold = 1'b0;
        wait_idle();
        chk_reg("R14 cfg write ignored", A_CFG, 8'h01);
        chk_reg("R14 stat after", A_STAT, f_stat(1,1,1,0,0,0));
        wr(A_CTRL, 8'h04);
        wr(A_CFG, 8'h00);
        chk_reg("R13 ctrl cleared", A_CTRL, 8'h00);
        chk_reg("R13 stat cleared", A_STAT, 8'h00);
        chk_reg("R13 cst cleared", A_CST, 8'h00);
        chk_reg("R13 eob cleared", A_EOB, 8'h00);
        wr(A_CFG, 8'h01);
        // restart cleanly
        wr(A_CTRL, 8'h01);
        wr(A_CTRL, 8'h02);
        wait_idle();
        wr(A_EOB, 8'h01);

        // random transactions
        for (int t = 0; t < 16; t++) begin
            if ($urandom % 2) write_txn(7'($urandom), 1 + $urandom % 4, 1'($urandom));
            else              read_txn(7'($urandom), 1 + $urandom % 4);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule